// File: doc/BRIEF.md
# Pointer-Programmed Memory Port Controller

This block lets a DSP reach three memories through six register-mapped ports. These are a 64K-word DRAM, a 1K-word internal RAM and a banked ROM. Software first builds a 32-bit pointer in a control register, using two 16-bit steps: an address word, then a mode word. The next access to a port register copies that pointer into one of twelve slots. A read access selects the port's read slot and a write access selects its write slot. Later accesses to that port move data between the DSP and memory, then advance the slot's address by an amount the mode word encodes.

Every access is offered with `acc_valid` and `acc_sel` and accepted when `acc_ready` is high. Exactly one cycle later `rsp_valid` pulses. With it, `rsp_plain` reports that the port behaved as an ordinary register, which the DSP core then handles itself. For reads, `rsp_data` carries the read word. DRAM and ROM are synchronous memories with one cycle of read latency. A masked overwrite of DRAM is a read followed by a write, so it holds `acc_ready` low for one cycle.

Top module: `pmx_port_ctl`

## Requirements
- R1: `acc_sel` 6 is the control register. After reset it holds zero in the idle state. A write in the have-address state loads the mode (upper half) and moves to the set state. A write in any other state loads the address (lower half) and moves to have-address.
- R2: A control read in have-address returns the address word rotated left by 4 (bits [11:0] to [15:4], bits [15:12] to [3:0]) and moves to set. In any other state it returns the address word unchanged and moves to have-address.
- R3: A port access (`acc_sel` 0..5 = N) in the set state copies the control value into slot N for a read or slot N+6 for a write. It returns the state to idle, moves no data, touches no memory, and gives `rsp_plain`=0 with read data 0.
- R4: A port access in the have-address state returns the state to idle and then proceeds as a normal port access.
- R5: A read of `acc_sel` 7 (accumulator low) returns 0 and clears the control state to idle.
- R6: Memory transfer happens only on port 4 or when `acc_status` is nonzero. Otherwise, or when the slot mode matches no rule, the access reports `rsp_plain`=1 and leaves memory and slots untouched.
- R7: Write mode with (mode & 0x43FF)==0x0018 writes DRAM at the address. The address then moves by the step field mode[13:11]: 0 gives 0, 1..6 give 1,2,4,8,16,32, and 7 gives 128. Mode bit 15 negates the step. Addresses wrap at 16 bits.
- R8: Write mode with (mode & 0xFBFF)==0x4018 writes DRAM in cell order. The address advances by 31 when it is odd and by 1 when it is even.
- R9: In the DRAM and cell write modes, mode bit 10 selects an overwrite. Only the nonzero nibbles of the data replace memory, and `acc_ready` is low for exactly the next cycle.
- R10: Write mode with (mode & 0x47FF)==0x001C writes internal RAM at address bits [9:0] and advances by the R7 step.
- R11: Read mode with (mode & 0xFFF0)==0x0800 reads ROM at {mode[3:0], address} and advances the address by exactly 1.
- R12: Read mode with (mode & 0x47FF)==0x0018 reads DRAM at the address and advances by the R7 step.
- R13: After each memory transfer the control register equals the updated slot, and its state is idle.
- R14: `rsp_valid` is high exactly one cycle after each accepted access. Read data appears in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Access accepted this cycle when high |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_sel | input | 3 | 0..5 port registers, 6 control register, 7 accumulator low |
| acc_wdata | input | 16 | Write data |
| acc_status | input | ST_W | DSP status bits that enable transfers on every port |
| rsp_valid | output | 1 | Response for the access accepted one cycle earlier |
| rsp_plain | output | 1 | Port acted as a plain register |
| rsp_data | output | 16 | Read data |
| dram_re | output | 1 | DRAM read enable |
| dram_we | output | 1 | DRAM write enable |
| dram_addr | output | 16 | DRAM word address |
| dram_wdata | output | 16 | DRAM write data |
| dram_rdata | input | 16 | DRAM read data, one cycle after `dram_re` |
| iram_we | output | 1 | Internal RAM write enable |
| iram_addr | output | IRAM_AW | Internal RAM word address |
| iram_wdata | output | 16 | Internal RAM write data |
| rom_re | output | 1 | ROM read enable |
| rom_addr | output | ROM_BANK_W+16 | ROM word address, bank over address |
| rom_rdata | input | 16 | ROM read data, one cycle after `rom_re` |

## Verification
The bench builds the block with its defaults: IRAM_AW of 10, ROM_BANK_W of 4, XFER_PORT of 4 and a 2-bit status input. This exposes the full 4-bit ROM bank field, the wrap of internal RAM addresses at bit 10, and both ways to open the transfer gate. The bench DRAM model decodes 12 address bits, so negative steps and 128-word strides alias back into a small array. This keeps read-after-write hits frequent and lets the complete contents be compared at the end. Random pointer programming over all twelve slots is mixed with directed runs through the rotation, the cell wrap, the nibble overwrite and the ROM address wrap.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_PORTS = 6;
    localparam int NUM_SLOTS = 2 * NUM_PORTS;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int NIBBLES   = WORD_W / 4;
    localparam logic [2:0] SEL_CTL = 3'd6;
    localparam logic [2:0] SEL_ACC = 3'd7;

    typedef enum logic [1:0] {CS_IDLE, CS_HAVE, CS_SET} ctl_state_e;
    typedef enum logic [2:0] {MK_NONE, MK_DRAM, MK_CELL, MK_IRAM, MK_ROM} mem_kind_e;
    typedef enum logic [1:0] {RS_REG, RS_DRAM, RS_ROM} rsp_src_e;
    typedef enum logic {PH_RUN, PH_MERGE} phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] mode;
        logic [WORD_W-1:0] addr;
    } ptr_t;

    typedef struct packed {
        mem_kind_e         kind;
        logic              ow;
        logic [WORD_W-1:0] step;
    } xfer_plan_t;

    function automatic logic [WORD_W-1:0] step_of(input logic [WORD_W-1:0] mode);
        logic [WORD_W-1:0] mag;
        case (mode[13:11])
            3'd0:    mag = '0;
            3'd7:    mag = WORD_W'(128);
            default: mag = WORD_W'(1) << (mode[13:11] - 3'd1);
        endcase
        return mode[15] ? (~mag + WORD_W'(1)) : mag;
    endfunction

    function automatic logic [WORD_W-1:0] rot_nib(input logic [WORD_W-1:0] w);
        return {w[WORD_W-5:0], w[WORD_W-1:WORD_W-4]};
    endfunction

    function automatic logic [WORD_W-1:0] ow_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w);
        logic [WORD_W-1:0] res;
        for (int n = 0; n < NIBBLES; n++) begin
            res[n*4 +: 4] = (new_w[n*4 +: 4] != 4'h0) ? new_w[n*4 +: 4] : old_w[n*4 +: 4];
        end
        return res;
    endfunction

endpackage

// File: rtl/pmx_ctl_seq.sv
module pmx_ctl_seq
    import pmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic              acc_rd,
    input  logic              port_hit,
    input  logic [WORD_W-1:0] wdata,
    input  logic              load_en,
    input  ptr_t              load_val,
    output ctl_state_e        state,
    output ptr_t              value,
    output logic [WORD_W-1:0] rd_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            value <= '0;
        end else begin
            if (ctl_wr) begin
                if (state == CS_HAVE) begin
                    value.mode <= wdata;
                    state      <= CS_SET;
                end else begin
                    value.addr <= wdata;
                    state      <= CS_HAVE;
                end
            end else if (ctl_rd) begin
                state <= (state == CS_HAVE) ? CS_SET : CS_HAVE;
            end else if (acc_rd || port_hit) begin
                state <= CS_IDLE;
            end
            if (load_en) begin
                value <= load_val;
            end
        end
    end

    assign rd_word = (state == CS_HAVE) ? rot_nib(value.addr) : value.addr;

    p_mode_load_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && state == CS_HAVE) |=> (state == CS_SET && value.mode == $past(wdata)));

    p_acc_clears_r5: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> (state == CS_IDLE));

    p_port_clears_r4: assert property (@(posedge clk) disable iff (rst)
        port_hit |=> (state == CS_IDLE));

endmodule

// File: rtl/pmx_ptr_bank.sv
module pmx_ptr_bank
    import pmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  ptr_t              wr_val,
    input  logic [SLOT_W-1:0] rd_idx,
    output ptr_t              rd_val
);

    ptr_t slot_q [NUM_SLOTS];

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[s] <= '0;
                end else if (wr_en && wr_idx == SLOT_W'(s)) begin
                    slot_q[s] <= wr_val;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_idx == SLOT_W'(s)) rd_val = slot_q[s];
        end
    end

endmodule

// File: rtl/pmx_mode_decode.sv
module pmx_mode_decode
    import pmx_pkg::*;
(
    input  logic       is_write,
    input  ptr_t       ptr,
    output xfer_plan_t plan
);

    logic [WORD_W-1:0] m;
    assign m = ptr.mode;

    always_comb begin
        plan = '{kind: MK_NONE, ow: 1'b0, step: '0};
        if (is_write) begin
            if ((m & 16'h43FF) == 16'h0018) begin
                plan = '{kind: MK_DRAM, ow: m[10], step: step_of(m)};
            end else if ((m & 16'hFBFF) == 16'h4018) begin
                plan = '{kind: MK_CELL, ow: m[10],
                         step: ptr.addr[0] ? WORD_W'(31) : WORD_W'(1)};
            end else if ((m & 16'h47FF) == 16'h001C) begin
                plan = '{kind: MK_IRAM, ow: 1'b0, step: step_of(m)};
            end
        end else begin
            if ((m & 16'hFFF0) == 16'h0800) begin
                plan = '{kind: MK_ROM, ow: 1'b0, step: WORD_W'(1)};
            end else if ((m & 16'h47FF) == 16'h0018) begin
                plan = '{kind: MK_DRAM, ow: 1'b0, step: step_of(m)};
            end
        end
    end

endmodule

// File: rtl/pmx_port_ctl.sv
module pmx_port_ctl
    import pmx_pkg::*;
#(
    parameter int IRAM_AW    = 10,
    parameter int ROM_BANK_W = 4,
    parameter int XFER_PORT  = 4,
    parameter int ST_W       = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         acc_valid,
    output logic                         acc_ready,
    input  logic                         acc_write,
    input  logic [2:0]                   acc_sel,
    input  logic [WORD_W-1:0]            acc_wdata,
    input  logic [ST_W-1:0]              acc_status,
    output logic                         rsp_valid,
    output logic                         rsp_plain,
    output logic [WORD_W-1:0]            rsp_data,
    output logic                         dram_re,
    output logic                         dram_we,
    output logic [WORD_W-1:0]            dram_addr,
    output logic [WORD_W-1:0]            dram_wdata,
    input  logic [WORD_W-1:0]            dram_rdata,
    output logic                         iram_we,
    output logic [IRAM_AW-1:0]           iram_addr,
    output logic [WORD_W-1:0]            iram_wdata,
    output logic                         rom_re,
    output logic [ROM_BANK_W+WORD_W-1:0] rom_addr,
    input  logic [WORD_W-1:0]            rom_rdata
);

    phase_e            phase;
    rsp_src_e          src_q;
    logic [WORD_W-1:0] reg_q;
    logic [WORD_W-1:0] pend_addr, pend_data;

    ctl_state_e        cst;
    ptr_t              ctl_val, cur, nxt;
    logic [WORD_W-1:0] ctl_word;
    xfer_plan_t        plan;

    logic              fire, is_port, latch, gate, do_xfer, ow_go;
    logic [SLOT_W-1:0] slot_idx;

    assign acc_ready = (phase == PH_RUN);
    assign fire      = acc_valid && acc_ready;
    assign is_port   = (acc_sel < 3'(NUM_PORTS));
    assign slot_idx  = acc_write ? SLOT_W'(acc_sel) + SLOT_W'(NUM_PORTS) : SLOT_W'(acc_sel);
    assign latch     = fire && is_port && (cst == CS_SET);
    assign gate      = (acc_sel == 3'(XFER_PORT)) || (|acc_status);
    assign do_xfer   = fire && is_port && (cst != CS_SET) && gate && (plan.kind != MK_NONE);
    assign ow_go     = do_xfer && acc_write && plan.ow;
    assign nxt       = '{mode: cur.mode, addr: cur.addr + plan.step};

    pmx_ctl_seq u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (fire && acc_sel == SEL_CTL && acc_write),
        .ctl_rd   (fire && acc_sel == SEL_CTL && !acc_write),
        .acc_rd   (fire && acc_sel == SEL_ACC && !acc_write),
        .port_hit (fire && is_port),
        .wdata    (acc_wdata),
        .load_en  (do_xfer),
        .load_val (nxt),
        .state    (cst),
        .value    (ctl_val),
        .rd_word  (ctl_word)
    );

    pmx_ptr_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (latch || do_xfer),
        .wr_idx (slot_idx),
        .wr_val (latch ? ctl_val : nxt),
        .rd_idx (slot_idx),
        .rd_val (cur)
    );

    pmx_mode_decode u_dec (
        .is_write (acc_write),
        .ptr      (cur),
        .plan     (plan)
    );

    // Memory side: accept-cycle commands, plus the merge write of an overwrite.
    assign dram_re    = do_xfer && (acc_write ? plan.ow : (plan.kind == MK_DRAM));
    assign dram_we    = (phase == PH_MERGE) ||
                        (do_xfer && acc_write && !plan.ow &&
                         (plan.kind == MK_DRAM || plan.kind == MK_CELL));
    assign dram_addr  = (phase == PH_MERGE) ? pend_addr : cur.addr;
    assign dram_wdata = (phase == PH_MERGE) ? ow_merge(dram_rdata, pend_data) : acc_wdata;
    assign iram_we    = do_xfer && acc_write && (plan.kind == MK_IRAM);
    assign iram_addr  = cur.addr[IRAM_AW-1:0];
    assign iram_wdata = acc_wdata;
    assign rom_re     = do_xfer && (plan.kind == MK_ROM);
    assign rom_addr   = {cur.mode[ROM_BANK_W-1:0], cur.addr};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_RUN;
            rsp_valid <= 1'b0;
            rsp_plain <= 1'b0;
            src_q     <= RS_REG;
            reg_q     <= '0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            phase     <= ow_go ? PH_MERGE : PH_RUN;
            rsp_valid <= fire;
            rsp_plain <= fire && is_port && !latch && !do_xfer;
            if (ow_go) begin
                pend_addr <= cur.addr;
                pend_data <= acc_wdata;
            end
            if (fire) begin
                src_q <= RS_REG;
                reg_q <= '0;
                if (acc_sel == SEL_CTL && !acc_write) begin
                    reg_q <= ctl_word;
                end else if (do_xfer && !acc_write) begin
                    src_q <= (plan.kind == MK_ROM) ? RS_ROM : RS_DRAM;
                end
            end
        end
    end

    always_comb begin
        case (src_q)
            RS_DRAM: rsp_data = dram_rdata;
            RS_ROM:  rsp_data = rom_rdata;
            default: rsp_data = reg_q;
        endcase
    end

    p_rsp_follows_r14: assert property (@(posedge clk) disable iff (rst)
        fire |=> rsp_valid);

    p_rsp_only_after_r14: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !rsp_valid);

    p_merge_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_ready |=> acc_ready);

    p_merge_writes_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_ready |-> (dram_we && !dram_re && !iram_we && !rom_re));

    p_latch_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        latch |-> (!dram_we && !dram_re && !iram_we && !rom_re));

    p_single_target_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({dram_we, iram_we, rom_re}) <= 1);

endmodule

// File: tb/pmx_port_ctl_test.sv
`timescale 1ns/1ps
module pmx_port_ctl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [15:0] acc_wdata = '0;
    logic [1:0]  acc_status = '0;
    logic        acc_ready, rsp_valid, rsp_plain;
    logic [15:0] rsp_data;
    logic        dram_re, dram_we, iram_we, rom_re;
    logic [15:0] dram_addr, dram_wdata, iram_wdata;
    logic [15:0] dram_q = '0, rom_q = '0;
    logic [9:0]  iram_addr;
    logic [19:0] rom_addr;

    always #2 clk = ~clk;

    pmx_port_ctl uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_write(acc_write), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
        .acc_status(acc_status), .rsp_valid(rsp_valid), .rsp_plain(rsp_plain),
        .rsp_data(rsp_data), .dram_re(dram_re), .dram_we(dram_we),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_q),
        .iram_we(iram_we), .iram_addr(iram_addr), .iram_wdata(iram_wdata),
        .rom_re(rom_re), .rom_addr(rom_addr), .rom_rdata(rom_q)
    );

    // Memory models (DRAM decodes 12 address bits)
    logic [15:0] m_dram [4096];
    logic [15:0] m_iram [1024];

    function automatic logic [15:0] rom_word(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], a[19:16], 8'h5A};
    endfunction
    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 7) ^ 16'h3C00;
    endfunction

    always @(posedge clk) begin
        if (dram_we) m_dram[dram_addr[11:0]] <= dram_wdata;
        if (dram_re) dram_q <= m_dram[dram_addr[11:0]];
        if (iram_we) m_iram[iram_addr] <= iram_wdata;
        if (rom_re)  rom_q <= rom_word(rom_addr);
    end

    // Reference state
    int          r_cst = 0;
    logic [31:0] r_ctl = '0;
    logic [31:0] r_slot [12];
    logic [15:0] r_dram [4096];
    logic [15:0] r_iram [1024];

    int unsigned n_chk = 0, n_bad = 0;
    bit          done = 0;

    function automatic logic [15:0] f_step(input logic [15:0] m);
        logic [15:0] g;
        if (m[13:11] == 3'd0) g = 16'd0;
        else if (m[13:11] == 3'd7) g = 16'd128;
        else g = 16'd1 << (m[13:11] - 1);
        return m[15] ? 16'(-g) : g;
    endfunction
    function automatic logic [15:0] f_rot(input logic [15:0] w);
        return {w[11:0], w[15:12]};
    endfunction
    function automatic logic [15:0] f_merge(input logic [15:0] o, input logic [15:0] n);
        logic [15:0] r;
        for (int k = 0; k < 4; k++) r[k*4 +: 4] = (n[k*4 +: 4] != 0) ? n[k*4 +: 4] : o[k*4 +: 4];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] sel, input logic wr, input logic [15:0] d,
                      input logic [1:0] st, output logic [15:0] got);
        logic [15:0] ed, m, a;
        logic        ep;
        string       tag;
        int          idx;
        ed = 0; ep = 0; tag = "R14";
        if (sel == 3'd6) begin
            tag = wr ? "R1" : "R2";
            if (wr) begin
                if (r_cst == 1) begin r_ctl[31:16] = d; r_cst = 2; end
                else begin r_ctl[15:0] = d; r_cst = 1; end
            end else begin
                if (r_cst == 1) begin ed = f_rot(r_ctl[15:0]); r_cst = 2; end
                else begin ed = r_ctl[15:0]; r_cst = 1; end
            end
        end else if (sel == 3'd7) begin
            tag = "R5";
            if (!wr) r_cst = 0;
        end else begin
            idx = wr ? int'(sel) + 6 : int'(sel);
            if (r_cst == 2) begin
                tag = "R3"; r_slot[idx] = r_ctl; r_cst = 0;
            end else begin
                if (r_cst == 1) tag = "R4";
                r_cst = 0;
                m = r_slot[idx][31:16]; a = r_slot[idx][15:0];
                ep = 1;
                if (sel == 3'd4 || st != 0) begin
                    if (wr) begin
                        if ((m & 16'h43FF) == 16'h0018) begin
                            tag = m[10] ? "R9" : "R7"; ep = 0;
                            r_dram[a[11:0]] = m[10] ? f_merge(r_dram[a[11:0]], d) : d;
                            a = a + f_step(m);
                        end else if ((m & 16'hFBFF) == 16'h4018) begin
                            tag = "R8"; ep = 0;
                            r_dram[a[11:0]] = m[10] ? f_merge(r_dram[a[11:0]], d) : d;
                            a = a + (a[0] ? 16'd31 : 16'd1);
                        end else if ((m & 16'h47FF) == 16'h001C) begin
                            tag = "R10"; ep = 0;
                            r_iram[a[9:0]] = d;
                            a = a + f_step(m);
                        end
                    end else begin
                        if ((m & 16'hFFF0) == 16'h0800) begin
                            tag = "R11"; ep = 0;
                            ed = rom_word({m[3:0], a}); a = a + 16'd1;
                        end else if ((m & 16'h47FF) == 16'h0018) begin
                            tag = "R12"; ep = 0;
                            ed = r_dram[a[11:0]]; a = a + f_step(m);
                        end
                    end
                    if (!ep) begin r_slot[idx] = {m, a}; r_ctl = {m, a}; end
                end
                if (ep) tag = "R6";
            end
        end
        @(negedge clk);
        while (!acc_ready) @(negedge clk);
        acc_valid = 1; acc_sel = sel; acc_write = wr; acc_wdata = d; acc_status = st;
        @(negedge clk);
        acc_valid = 0;
        got = rsp_data;
        chk(rsp_valid === 1'b1, "R14", 32'(rsp_valid), 32'd1);
        if (sel < 3'd6) chk(rsp_plain === ep, tag, 32'(rsp_plain), 32'(ep));
        if (!wr && !ep) chk(rsp_data === ed, tag, 32'(rsp_data), 32'(ed));
    endtask

    task automatic prog(input logic [2:0] sel, input logic wr, input logic [15:0] mode,
                        input logic [15:0] addr);
        logic [15:0] g;
        op(3'd7, 0, 0, 0, g);
        op(3'd6, 1, addr, 0, g);
        op(3'd6, 1, mode, 0, g);
        op(sel, wr, 16'hDEAD, 0, g);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL R14: watchdog expired actual 0 expected 1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] g;
        logic [15:0] mode;
        for (int i = 0; i < 4096; i++) begin m_dram[i] = init_word(i); r_dram[i] = init_word(i); end
        for (int i = 0; i < 1024; i++) begin m_iram[i] = 16'(i); r_iram[i] = 16'(i); end
        for (int i = 0; i < 12; i++) r_slot[i] = '0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(acc_ready === 1'b1 && rsp_valid === 1'b0, "R1", {acc_ready, rsp_valid}, 32'h2);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h0000, "R1", g, 0);
        op(3'd7, 0, 0, 0, g);  chk(g === 16'h0000, "R5", g, 0);

        // rotation and state walk
        op(3'd6, 1, 16'h1234, 0, g);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h2341, "R2", g, 16'h2341);
        op(3'd7, 0, 0, 0, g);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h1234, "R5", g, 16'h1234);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h2341, "R2", g, 16'h2341);

        // have-address cleared by a port access
        op(3'd7, 0, 0, 0, g);
        op(3'd6, 1, 16'h1234, 0, g);
        op(3'd0, 0, 0, 0, g);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h1234, "R4", g, 16'h1234);

        // DRAM write step 2 then read back
        prog(3'd4, 1, 16'h1018, 16'h0100);
        op(3'd4, 1, 16'hAAAA, 0, g);
        op(3'd4, 1, 16'hBBBB, 0, g);
        prog(3'd4, 0, 16'h1018, 16'h0100);
        op(3'd4, 0, 0, 0, g);  chk(g === 16'hAAAA, "R12", g, 16'hAAAA);
        op(3'd4, 0, 0, 0, g);  chk(g === 16'hBBBB, "R7", g, 16'hBBBB);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h0104, "R13", g, 16'h0104);

        // overwrite with nibble mask
        prog(3'd4, 1, 16'h0418, 16'h0200);
        op(3'd4, 1, 16'h00F0, 0, g);
        prog(3'd4, 0, 16'h0018, 16'h0200);
        op(3'd4, 0, 0, 0, g);
        chk(g === ((init_word(16'h200) & 16'hFF0F) | 16'h00F0), "R9", g,
            (init_word(16'h200) & 16'hFF0F) | 16'h00F0);

        // cell order
        prog(3'd4, 1, 16'h4018, 16'h0301);
        op(3'd4, 1, 16'h1111, 0, g);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h0320, "R8", g, 16'h0320);
        op(3'd4, 1, 16'h2222, 0, g);
        op(3'd7, 0, 0, 0, g);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h0321, "R8", g, 16'h0321);

        // ROM bank and address wrap, gated by status on port 1
        prog(3'd1, 0, 16'h0805, 16'hFFFF);
        op(3'd1, 0, 0, 2'b01, g); chk(g === rom_word(20'h5FFFF), "R11", g, rom_word(20'h5FFFF));
        op(3'd1, 0, 0, 2'b10, g); chk(g === rom_word(20'h50000), "R11", g, rom_word(20'h50000));
        op(3'd1, 0, 0, 2'b00, g); chk(rsp_plain === 1'b1, "R6", 32'(rsp_plain), 1);

        // internal RAM with negative step and large stride
        prog(3'd4, 1, 16'h881C, 16'h0005);
        op(3'd4, 1, 16'h7777, 0, g);
        op(3'd4, 1, 16'h8888, 0, g);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h0003, "R10", g, 16'h0003);
        prog(3'd4, 1, 16'h3818, 16'h0010);
        op(3'd4, 1, 16'h4444, 0, g);
        op(3'd6, 0, 0, 0, g);  chk(g === 16'h0090, "R7", g, 16'h0090);

        // random mix
        for (int it = 0; it < 1500; it++) begin
            int          kind;
            logic [2:0]  s;
            logic        w;
            kind = int'($urandom % 10);
            s = 3'($urandom % 6);
            w = 1'($urandom);
            if (kind < 2) begin
                case ($urandom % 6)
                    0: mode = 16'h0018 | 16'($urandom & 32'h8C00) | 16'(($urandom % 8) << 11);
                    1: mode = 16'h4018 | 16'($urandom & 32'h0400);
                    2: mode = 16'h001C | 16'($urandom & 32'h8000) | 16'(($urandom % 8) << 11);
                    3: mode = 16'h0800 | 16'($urandom % 16);
                    4: mode = 16'h0018 | 16'($urandom & 32'h8000) | 16'(($urandom % 8) << 11);
                    default: mode = 16'($urandom);
                endcase
                prog(s, w, mode, 16'($urandom));
            end else if (kind == 2) begin
                op(3'd6, w, 16'($urandom), 0, g);
            end else if (kind == 3) begin
                op(3'd7, 0, 0, 0, g);
            end else begin
                op(s, w, 16'($urandom), 2'($urandom % 4), g);
            end
        end

        repeat (3) @(negedge clk);
        for (int i = 0; i < 4096; i++)
            if (m_dram[i] !== r_dram[i]) chk(0, "R7", m_dram[i], r_dram[i]);
        chk(1, "R7", 0, 0);
        for (int i = 0; i < 1024; i++)
            if (m_iram[i] !== r_iram[i]) chk(0, "R10", m_iram[i], r_iram[i]);
        chk(1, "R10", 0, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule